// File: doc/BRIEF.md
# Jump-Counter Microsequencer

This block is the control unit of a small multicycle processor that runs five instruction kinds: register-register arithmetic, OR with an immediate, word load, word store and branch-on-equal. A four-bit micro-program counter addresses a microcode store. Each microcode word carries the datapath control fields, a two-bit sequencing action and a flag that marks the word as one that waits on memory. The next micro-address comes from a counter that can clear to zero, step by one, load a target from an opcode-indexed map, or hold its value.

Every instruction starts with a shared fetch word at micro-address 0 and a shared decode word at micro-address 1. The decode word jumps through the map to the first execute word of that instruction. The middle words step by one, and the last word of each instruction clears the counter back to fetch. A wait from memory during a fetch or data-memory word holds the counter, so that word repeats until memory is ready. The datapath and its memories sit outside the block. All control outputs are combinational decodes of the current word and of the `taken` and `mem_wait` inputs.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 at once, with no clock edge needed. After `rst_n` rises, the counter stays frozen for two more rising clock edges.
- R2: The word at micro-address 0 asserts `imem_rd` and `ir_en`. When `mem_wait` is low, the counter steps to 1.
- R3: When `mem_wait` is high at micro-address 0, 7 or 10, `upc` holds. In the same cycle `ir_en`, `m_en` and `pc_en` are low, while the memory request (`imem_rd`, `dmem_rd` or `dmem_wr`) stays asserted.
- R4: The word at micro-address 1 asserts `a_en`, `b_en` and `e_en` and loads the map target for `opcode`. The map is: 000000 goes to 2, 001101 goes to 4, 100011 goes to 6, 101011 goes to 9, and 000100 goes to 11.
- R5: Any opcode not listed in R4 makes the decode word return to micro-address 0.
- R6: Register type runs two words. Word 2 has `alu_op`=10 (function field) and `s_en`. Word 3 has `reg_wr`, `reg_dst_rd` and `pc_en`.
- R7: OR-immediate runs two words. Word 4 has `alu_op`=01, `alu_src_imm`, `ext_sign`=0 and `s_en`. Word 5 has `reg_wr` and `pc_en`, with `reg_dst_rd`=0.
- R8: Load runs three words. Word 6 has `alu_op`=00 (add), `alu_src_imm`, `ext_sign` and `s_en`. Word 7 has `dmem_rd` and `m_en`. Word 8 has `reg_wr`, `mem_to_reg` and `pc_en`.
- R9: Store runs two words. Word 9 has the same address calculation as word 6. Word 10 has `dmem_wr` and `pc_en`.
- R10: Branch is word 11. It asserts `pc_en`, and `pc_br` equals `taken`.
- R11: The last word of each instruction (3, 5, 8, 10, 11) moves `upc` to 0. Every middle word steps `upc` by one.
- R12: `mem_wait` has no effect on the counter or on the outputs at any micro-address other than 0, 7 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| taken | input | 1 | Branch condition (operands equal) |
| mem_wait | input | 1 | Memory not ready |
| upc | output | 4 | Current micro-address |
| imem_rd | output | 1 | Instruction memory read |
| ir_en | output | 1 | Instruction register enable |
| a_en | output | 1 | Operand A register enable |
| b_en | output | 1 | Operand B register enable |
| e_en | output | 1 | Equal flag register enable |
| alu_op | output | 2 | ALU operation: 00 add, 01 or, 10 function field |
| alu_src_imm | output | 1 | ALU second operand is the extended immediate |
| ext_sign | output | 1 | Sign-extend the immediate (0 = zero-extend) |
| s_en | output | 1 | ALU result register enable |
| dmem_rd | output | 1 | Data memory read |
| dmem_wr | output | 1 | Data memory write |
| m_en | output | 1 | Memory data register enable |
| reg_wr | output | 1 | Register file write |
| reg_dst_rd | output | 1 | Write destination is rd (0 = rt) |
| mem_to_reg | output | 1 | Write-back data from memory register |
| pc_en | output | 1 | PC update enable |
| pc_br | output | 1 | PC takes branch target (0 = PC + 4) |

## Verification
The control outputs depend only on the current micro-address and on the `taken` and `mem_wait` inputs, with no register in between. They are therefore due in the same cycle the inputs are applied. The micro-address itself changes one rising edge later. The bench applies each row of its table just after a falling edge and samples two time units later. Each row lists the micro-address expected in that cycle, so every lookup, step, hold and return to fetch is checked exactly one edge after the input that caused it. Reset entry is sampled with no clock edge in between. Reset release is given its two synchronizer edges before the counter is expected to move.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int OPC_W    = 6;
  localparam int UA_W     = 4;
  localparam int UA_DEPTH = 1 << UA_W;
  localparam int ALU_W    = 2;

  typedef enum logic [1:0] {
    SQ_ZERO = 2'b00,
    SQ_INC  = 2'b01,
    SQ_LOAD = 2'b10,
    SQ_HOLD = 2'b11
  } seq_e;

  localparam logic [ALU_W-1:0] ALU_ADD = 2'b00;
  localparam logic [ALU_W-1:0] ALU_OR  = 2'b01;
  localparam logic [ALU_W-1:0] ALU_FUN = 2'b10;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'b000100;

  // micro-address layout
  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_RTYPE  = 2;
  localparam int UA_ORI    = 4;
  localparam int UA_LOAD   = 6;
  localparam int UA_STORE  = 9;
  localparam int UA_BRANCH = 11;

  typedef struct packed {
    seq_e             seq;
    logic             wsens;
    logic             imem_rd;
    logic             ir_en;
    logic             a_en;
    logic             b_en;
    logic             e_en;
    logic [ALU_W-1:0] alu_op;
    logic             alu_src_imm;
    logic             ext_sign;
    logic             s_en;
    logic             dmem_rd;
    logic             dmem_wr;
    logic             m_en;
    logic             reg_wr;
    logic             reg_dst_rd;
    logic             mem_to_reg;
    logic             pc_en;
    logic             br_sel;
  } uword_t;

endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/useq_map.sv
module useq_map
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [AW-1:0]    tgt
);

  always_comb begin
    case (opcode)
      OP_RTYPE: tgt = AW'(UA_RTYPE);
      OP_ORI:   tgt = AW'(UA_ORI);
      OP_LOAD:  tgt = AW'(UA_LOAD);
      OP_STORE: tgt = AW'(UA_STORE);
      OP_BEQ:   tgt = AW'(UA_BRANCH);
      default:  tgt = AW'(UA_FETCH);
    endcase
  end

endmodule

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);

  localparam int DEPTH = 1 << AW;

  function automatic uword_t mk_word(int a);
    uword_t w;
    w     = '0;
    w.seq = SQ_ZERO;
    case (a)
      UA_FETCH: begin
        w.seq = SQ_INC;  w.wsens = 1'b1;
        w.imem_rd = 1'b1; w.ir_en = 1'b1;
      end
      UA_DECODE: begin
        w.seq = SQ_LOAD;
        w.a_en = 1'b1; w.b_en = 1'b1; w.e_en = 1'b1;
      end
      UA_RTYPE: begin
        w.seq = SQ_INC; w.alu_op = ALU_FUN; w.s_en = 1'b1;
      end
      UA_RTYPE + 1: begin
        w.reg_wr = 1'b1; w.reg_dst_rd = 1'b1; w.pc_en = 1'b1;
      end
      UA_ORI: begin
        w.seq = SQ_INC; w.alu_op = ALU_OR;
        w.alu_src_imm = 1'b1; w.s_en = 1'b1;
      end
      UA_ORI + 1: begin
        w.reg_wr = 1'b1; w.pc_en = 1'b1;
      end
      UA_LOAD, UA_STORE: begin
        w.seq = SQ_INC; w.alu_op = ALU_ADD;
        w.alu_src_imm = 1'b1; w.ext_sign = 1'b1; w.s_en = 1'b1;
      end
      UA_LOAD + 1: begin
        w.seq = SQ_INC; w.wsens = 1'b1;
        w.dmem_rd = 1'b1; w.m_en = 1'b1;
      end
      UA_LOAD + 2: begin
        w.reg_wr = 1'b1; w.mem_to_reg = 1'b1; w.pc_en = 1'b1;
      end
      UA_STORE + 1: begin
        w.wsens = 1'b1; w.dmem_wr = 1'b1; w.pc_en = 1'b1;
      end
      UA_BRANCH: begin
        w.pc_en = 1'b1; w.br_sel = 1'b1;
      end
      default: w = w;
    endcase
    return w;
  endfunction

  uword_t store [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      assign store[g] = mk_word(g);
    end
  endgenerate

  assign word = store[addr];

endmodule

// File: rtl/useq_upc.sv
module useq_upc
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_e          act,
  input  logic [AW-1:0] map_tgt,
  output logic [AW-1:0] upc
);

  logic [AW-1:0] upc_d;
  logic          upc_en;

  always_comb begin
    upc_en = (act != SQ_HOLD);
    case (act)
      SQ_ZERO: upc_d = '0;
      SQ_INC:  upc_d = upc + AW'(1);
      SQ_LOAD: upc_d = map_tgt;
      default: upc_d = upc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc <= '0;
    end else if (upc_en) begin
      upc <= upc_d;
    end
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             taken,
  input  logic             mem_wait,
  output logic [UA_W-1:0]  upc,
  output logic             imem_rd,
  output logic             ir_en,
  output logic             a_en,
  output logic             b_en,
  output logic             e_en,
  output logic [ALU_W-1:0] alu_op,
  output logic             alu_src_imm,
  output logic             ext_sign,
  output logic             s_en,
  output logic             dmem_rd,
  output logic             dmem_wr,
  output logic             m_en,
  output logic             reg_wr,
  output logic             reg_dst_rd,
  output logic             mem_to_reg,
  output logic             pc_en,
  output logic             pc_br
);

  logic            rst_sync_n;
  uword_t          uw;
  logic [UA_W-1:0] map_tgt;
  logic            stall;
  logic            commit;
  seq_e            act;

  useq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  useq_rom #(.AW(UA_W)) u_rom (
    .addr (upc),
    .word (uw)
  );

  useq_map #(.AW(UA_W)) u_map (
    .opcode (opcode),
    .tgt    (map_tgt)
  );

  // a waiting word repeats and withholds its register commits
  assign stall  = uw.wsens & mem_wait;
  assign commit = ~stall;
  assign act    = stall ? SQ_HOLD : uw.seq;

  useq_upc #(.AW(UA_W)) u_upc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .act     (act),
    .map_tgt (map_tgt),
    .upc     (upc)
  );

  assign imem_rd     = uw.imem_rd;
  assign ir_en       = uw.ir_en & commit;
  assign a_en        = uw.a_en;
  assign b_en        = uw.b_en;
  assign e_en        = uw.e_en;
  assign alu_op      = uw.alu_op;
  assign alu_src_imm = uw.alu_src_imm;
  assign ext_sign    = uw.ext_sign;
  assign s_en        = uw.s_en;
  assign dmem_rd     = uw.dmem_rd;
  assign dmem_wr     = uw.dmem_wr;
  assign m_en        = uw.m_en & commit;
  assign reg_wr      = uw.reg_wr;
  assign reg_dst_rd  = uw.reg_dst_rd;
  assign mem_to_reg  = uw.mem_to_reg;
  assign pc_en       = uw.pc_en & commit;
  assign pc_br       = uw.br_sel & taken;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
  import useq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] opcode,
  input logic             taken,
  input logic             mem_wait,
  input logic [UA_W-1:0]  upc,
  input logic             ir_en,
  input logic             m_en,
  input logic             pc_en,
  input logic             pc_br,
  input logic             a_en,
  input logic             b_en,
  input logic             e_en,
  input logic             dmem_rd,
  input logic             dmem_wr
);

  logic wait_word;
  assign wait_word = (int'(upc) == UA_FETCH) || (int'(upc) == UA_LOAD + 1) ||
                     (int'(upc) == UA_STORE + 1);

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(upc) == UA_FETCH && !mem_wait) |=> int'(upc) == UA_DECODE);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_word && mem_wait) |=> $stable(upc));

  a_r3_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_word && mem_wait) |-> !(ir_en || m_en || pc_en));

  a_r4_decode_en: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(upc) == UA_DECODE) |-> (a_en && b_en && e_en));

  a_r4_load_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(upc) == UA_DECODE && opcode == OP_LOAD) |=> int'(upc) == UA_LOAD);

  a_r5_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(upc) == UA_DECODE && opcode == 6'b111111) |=> int'(upc) == UA_FETCH);

  a_r9_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_rd && dmem_wr));

  a_r10_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(upc) == UA_BRANCH && taken) |-> (pc_en && pc_br));

  a_r11_retire: assert property (@(posedge clk) disable iff (!rst_n)
    pc_en |=> int'(upc) == UA_FETCH);

  a_r12_wait_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(upc) == UA_RTYPE && mem_wait) |=> int'(upc) == UA_RTYPE + 1);

endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .opcode   (opcode),
  .taken    (taken),
  .mem_wait (mem_wait),
  .upc      (upc),
  .ir_en    (ir_en),
  .m_en     (m_en),
  .pc_en    (pc_en),
  .pc_br    (pc_br),
  .a_en     (a_en),
  .b_en     (b_en),
  .e_en     (e_en),
  .dmem_rd  (dmem_rd),
  .dmem_wr  (dmem_wr)
);

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb;

  localparam logic [5:0] T_R = 6'b000000;
  localparam logic [5:0] T_I = 6'b001101;
  localparam logic [5:0] T_L = 6'b100011;
  localparam logic [5:0] T_S = 6'b101011;
  localparam logic [5:0] T_B = 6'b000100;
  localparam logic [5:0] T_X = 6'b111111;
  localparam int NV = 35;

  // {opcode, taken, mem_wait, expected upc in that cycle}
  localparam logic [11:0] VEC [NV] = '{
    {T_R,1'b0,1'b0,4'd0}, {T_R,1'b0,1'b0,4'd1}, {T_R,1'b0,1'b0,4'd2}, {T_R,1'b0,1'b0,4'd3},
    {T_I,1'b0,1'b1,4'd0}, {T_I,1'b0,1'b1,4'd0}, {T_I,1'b0,1'b0,4'd0}, {T_I,1'b0,1'b0,4'd1},
    {T_I,1'b0,1'b0,4'd4}, {T_I,1'b0,1'b0,4'd5},
    {T_L,1'b0,1'b0,4'd0}, {T_L,1'b0,1'b0,4'd1}, {T_L,1'b0,1'b0,4'd6}, {T_L,1'b0,1'b1,4'd7},
    {T_L,1'b0,1'b1,4'd7}, {T_L,1'b0,1'b0,4'd7}, {T_L,1'b0,1'b0,4'd8},
    {T_S,1'b0,1'b0,4'd0}, {T_S,1'b0,1'b0,4'd1}, {T_S,1'b0,1'b0,4'd9}, {T_S,1'b0,1'b1,4'd10},
    {T_S,1'b0,1'b0,4'd10},
    {T_B,1'b0,1'b0,4'd0}, {T_B,1'b0,1'b0,4'd1}, {T_B,1'b1,1'b0,4'd11},
    {T_B,1'b0,1'b0,4'd0}, {T_B,1'b0,1'b0,4'd1}, {T_B,1'b0,1'b0,4'd11},
    {T_X,1'b0,1'b0,4'd0}, {T_X,1'b0,1'b0,4'd1},
    {T_R,1'b0,1'b0,4'd0}, {T_R,1'b0,1'b1,4'd1}, {T_R,1'b1,1'b1,4'd2}, {T_R,1'b0,1'b1,4'd3},
    {T_R,1'b0,1'b1,4'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       taken;
  logic       mem_wait;
  logic [3:0] upc;
  logic       imem_rd, ir_en, a_en, b_en, e_en;
  logic [1:0] alu_op;
  logic       alu_src_imm, ext_sign, s_en, dmem_rd, dmem_wr, m_en;
  logic       reg_wr, reg_dst_rd, mem_to_reg, pc_en, pc_br;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  useq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .taken(taken), .mem_wait(mem_wait),
    .upc(upc), .imem_rd(imem_rd), .ir_en(ir_en), .a_en(a_en), .b_en(b_en), .e_en(e_en),
    .alu_op(alu_op), .alu_src_imm(alu_src_imm), .ext_sign(ext_sign), .s_en(s_en),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .m_en(m_en), .reg_wr(reg_wr),
    .reg_dst_rd(reg_dst_rd), .mem_to_reg(mem_to_reg), .pc_en(pc_en), .pc_br(pc_br)
  );

  wire [18:0] ctl = {imem_rd, ir_en, a_en, b_en, e_en, alu_op, alu_src_imm, ext_sign,
                     s_en, dmem_rd, dmem_wr, m_en, reg_wr, reg_dst_rd, mem_to_reg,
                     pc_en, pc_br};

  // expected control bundle, from R2..R10 and R3 gating
  function automatic logic [18:0] exp_ctl(int u, logic tk, logic wt);
    logic imr, ire, ae, be, ee, asi, es, se, dr, dw, me, rw, rd, mr, pe, pb;
    logic [1:0] ao;
    {imr, ire, ae, be, ee, asi, es, se, dr, dw, me, rw, rd, mr, pe, pb} = '0;
    ao = 2'b00;
    case (u)
      0:  begin imr = 1; ire = !wt; end
      1:  begin ae = 1; be = 1; ee = 1; end
      2:  begin ao = 2'b10; se = 1; end
      3:  begin rw = 1; rd = 1; pe = 1; end
      4:  begin ao = 2'b01; asi = 1; se = 1; end
      5:  begin rw = 1; pe = 1; end
      6, 9: begin asi = 1; es = 1; se = 1; end
      7:  begin dr = 1; me = !wt; end
      8:  begin rw = 1; mr = 1; pe = 1; end
      10: begin dw = 1; pe = !wt; end
      11: begin pe = 1; pb = tk; end
      default: ;
    endcase
    return {imr, ire, ae, be, ee, ao, asi, es, se, dr, dw, me, rw, rd, mr, pe, pb};
  endfunction

  function automatic string tag_of(int u);
    case (u)
      0: return "R2";
      1: return "R4";
      2, 3: return "R6";
      4, 5: return "R7";
      6, 7, 8: return "R8";
      9, 10: return "R9";
      11: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    string t;
    rst_n = 1'b0; opcode = T_R; taken = 1'b0; mem_wait = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R1", 32'(upc), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check("R1", 32'(upc), 32'd0);
    check("R3", 32'(ctl), 32'(exp_ctl(0, 1'b0, 1'b1)));

    prev = 0;
    for (int i = 0; i < NV; i++) begin
      int eu;
      @(negedge clk);
      opcode   = VEC[i][11:6];
      taken    = VEC[i][5];
      mem_wait = VEC[i][4];
      eu       = int'(VEC[i][3:0]);
      #2;
      if (prev == 1) t = (eu == 0) ? "R5" : "R4";
      else if (VEC[i][4] && (eu == 0 || eu == 7 || eu == 10)) t = "R3";
      else if (VEC[i][4]) t = "R12";
      else t = "R11";
      check(t, 32'(upc), 32'(eu));
      t = (VEC[i][4] && !(eu == 0 || eu == 7 || eu == 10)) ? "R12" : tag_of(eu);
      check(t, 32'(ctl), 32'(exp_ctl(eu, VEC[i][5], VEC[i][4])));
      prev = eu;
    end

    // reset in mid-instruction takes effect without a clock edge (R1)
    @(negedge clk); opcode = T_R; mem_wait = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #2;
    check("R6", 32'(upc), 32'd2);
    rst_n = 1'b0; mem_wait = 1'b1;
    #2;
    check("R1", 32'(upc), 32'd0);
    check("R3", 32'({imem_rd, ir_en}), 32'b10);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R3", 32'(upc), 32'd0);
    mem_wait = 1'b0;
    @(negedge clk);
    #2;
    check("R2", 32'(upc), 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule